// File: doc/BRIEF.md
# Two-Wire Configuration Register File

This block is a two-wire serial (I2C) target that holds the configuration of a small redundancy switch. A host on the bus writes a one-byte register pointer followed by one data byte, or sets the pointer and then, after a repeated START, reads one byte back. Five 8-bit registers are kept. The first holds a mask that picks whether each switching control comes from a pin or from a register. The next three hold the settings of ports A, B and C: output enable, loopback, equalisation and a 2-bit pre-emphasis level. The last holds the bicast and select bits. Their contents leave the block on parallel outputs for the control arbiter.

The bus lines are sampled on a system clock running at least 16 times the bus clock. Each line passes through a two-stage synchroniser and an edge detector. The block only ever pulls SDA low and never drives it high. The 7-bit device address is a fixed upper nibble, 1001, joined to three strap pins. The register pointer is kept from one transfer to the next until it is written again or the block is reset.

Top module: `cfg_i2c_regfile`

## Requirements
- R1: The device address is {4'b1001, addr_pins}, for example 0x4B with pins 3'b011. A matching address byte is acknowledged: SDA is held low for the ninth SCL clock. Bit 0 of the address byte selects write (0) or read (1).
- R2: An address byte that does not match is not acknowledged. Every later byte is ignored, including one that carries the right address, and no register changes until the next START.
- R3: A write transfer is a pointer byte and then a data byte, both sent MSB first and both acknowledged. The data byte lands in the register the pointer names. Register outputs change only while SCL is low.
- R4: The register at pointer 0 drives mask_cfg, 1 drives port_a_cfg, 2 drives port_b_cfg, 3 drives port_c_cfg and 4 drives switch_cfg. Pointers 0 and 4 reset to 0x00. Pointers 1 to 3 reset to 0x10, where bit 4 is output enable, bit 3 loopback, bit 2 equalisation and bits 1:0 pre-emphasis.
- R5: After an acknowledged read address, the block shifts out the 8 bits of the pointed register, MSB first. Each bit is placed on SDA while SCL is low.
- R6: The pointer survives STOP and START. A read with no pointer phase returns the register named by the last pointer byte written.
- R7: A pointer above 0x04 is acknowledged, and so is the data byte that follows it, but the data is discarded. A read at such a pointer returns 0x00.
- R8: A repeated START in any state opens a new address phase, so transfers can be chained without a STOP.
- R9: A low rst_n, sampled on the clock, returns every register to its default and the pointer to 0x00.
- R10: sda_drive_low is asserted only to pull SDA low. It changes only while the synchronised SCL is low, and it is released after a STOP.
- R11: Only one data byte is taken per write transfer. A second data byte in the same transfer is not acknowledged and not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_pins | input | 3 | Strap pins forming the low three address bits |
| sda_drive_low | output | 1 | 1 = pull SDA low (open-drain enable) |
| mask_cfg | output | 8 | Register 0x00: control-source mask |
| port_a_cfg | output | 8 | Register 0x01: port A settings |
| port_b_cfg | output | 8 | Register 0x02: port B settings |
| port_c_cfg | output | 8 | Register 0x03: port C settings |
| switch_cfg | output | 8 | Register 0x04: bit1 bicast, bit0 select |

## Verification
The assertions assume a well-behaved controller on the bus. It changes SDA only while SCL is low, except to form START and STOP, and it never tries a START or STOP while the block is holding SDA low. The bench's bus tasks keep to this. SDA is set a quarter period after each SCL fall, SCL is held high and low for 16 system clocks each, and START and STOP are issued only while the block has released the line. The pins are strapped while the bus is idle, and reset is applied only between transfers.

// File: rtl/cfg_i2c_pkg.sv
// Shared constants, the engine state type and the register defaults of
// the two-wire configuration register file.
package cfg_i2c_pkg;

    localparam int REG_W    = 8;                 // register and byte width
    localparam int NUM_REGS = 5;                 // registers in the map
    localparam int PIN_W    = 3;                 // strap pins in the address
    localparam int CNT_W    = $clog2(REG_W + 1); // bit counter width
    localparam logic [3:0] DEV_HI = 4'b1001;     // fixed address nibble

    // Protocol engine states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_PTR,
        ST_ACK_PTR,
        ST_WDATA,
        ST_ACK_DATA,
        ST_TX,
        ST_IGNORE
    } eng_state_t;

    // Reset value of each register: the three port registers come up
    // with their output enabled, all others cleared.
    function automatic logic [REG_W-1:0] reg_default(input int idx);
        return (idx >= 1 && idx <= 3) ? 8'h10 : 8'h00;
    endfunction

endpackage

// File: rtl/cfg_line_sync.sv
// Two-stage synchroniser for one bus line, with one extra flop that
// keeps the previous synchronised value for edge detection.
// Assumes the line idles high, so every flop resets to 1.
module cfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic line_p
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the asynchronous line through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign line_s = chain_q[STAGES-1];
    assign line_p = prev_q;

endmodule

// File: rtl/cfg_i2c_engine.sv
// Byte-level two-wire target engine. It finds START and STOP, matches
// the address, acknowledges, keeps the register pointer, issues a
// one-cycle write strobe for the data byte, and shifts out read data.
// Assumes synchronised line samples from a clock at least 16x SCL, and
// that the controller never stretches or shares the clock.
module cfg_i2c_engine
    import cfg_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_s,
    input  logic               scl_p,
    input  logic               sda_s,
    input  logic               sda_p,
    input  logic [PIN_W-1:0]   dev_pins,
    input  logic [REG_W-1:0]   rd_data,
    output logic               wr_en,
    output logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   ptr,
    output logic               sda_low,
    output logic               start_det,
    output logic               stop_det,
    output eng_state_t         state_o
);

    eng_state_t       state;
    logic [CNT_W-1:0] bit_cnt;
    logic [REG_W-1:0] rx_sr;
    logic [REG_W-1:0] tx_sr;
    logic             rw_bit;
    logic             scl_rise;
    logic             scl_fall;
    logic             byte_end;
    logic             addr_hit;

    // Bus events taken from the synchronised samples
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
        byte_end  = scl_fall && (bit_cnt == CNT_W'(REG_W));
        addr_hit  = (rx_sr[REG_W-1:1] == {DEV_HI, dev_pins});
    end

    // Protocol state machine, shifters, pointer and SDA pull-down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            rw_bit  <= 1'b0;
            ptr     <= '0;
            sda_low <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_low <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_low <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[REG_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_low <= 1'b1;
                                    rw_bit  <= rx_sr[0];
                                    state   <= ST_ACK_ADDR;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr     <= rx_sr;
                                sda_low <= 1'b1;
                                state   <= ST_ACK_PTR;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= rx_sr;
                                sda_low <= 1'b1;
                                state   <= ST_ACK_DATA;
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (scl_fall) begin
                            if (rw_bit) begin
                                tx_sr   <= {rd_data[REG_W-2:0], 1'b0};
                                sda_low <= ~rd_data[REG_W-1];
                                state   <= ST_TX;
                            end else begin
                                sda_low <= 1'b0;
                                state   <= ST_PTR;
                            end
                        end
                    end
                    ST_ACK_PTR: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            state   <= ST_WDATA;
                        end
                    end
                    ST_ACK_DATA: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            state   <= ST_IGNORE;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            bit_cnt <= '0;
                            sda_low <= 1'b0;
                            state   <= ST_IGNORE;
                        end else if (scl_fall) begin
                            sda_low <= ~tx_sr[REG_W-1];
                            tx_sr   <= {tx_sr[REG_W-2:0], 1'b0};
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        bit_cnt <= '0;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign state_o = state;

endmodule

// File: rtl/cfg_reg_bank.sv
// Configuration register storage with reset defaults. A write to a
// pointer outside the map is dropped, and a read there returns zero.
// Assumes a one-cycle write strobe from the engine.
module cfg_reg_bank
    import cfg_i2c_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [REG_W-1:0]                wr_addr,
    input  logic [REG_W-1:0]                wr_data,
    input  logic [REG_W-1:0]                rd_addr,
    output logic [REG_W-1:0]                rd_data,
    output logic [NUM_REGS-1:0][REG_W-1:0]  regs_o
);

    logic [REG_W-1:0] regs_q [NUM_REGS];

    // Load defaults on reset and accept strobed writes to mapped entries
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) begin
                regs_q[i] <= reg_default(i);
            end else if (wr_en && (wr_addr == REG_W'(i))) begin
                regs_q[i] <= wr_data;
            end
        end
    end

    // Read mux; a pointer outside the map returns zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == REG_W'(i)) rd_data = regs_q[i];
        end
    end

    // Bring every entry out on the packed output bus
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign regs_o[g] = regs_q[g];
    end

endmodule

// File: rtl/cfg_i2c_regfile.sv
// Top of the two-wire configuration register file. It synchronises
// both bus lines, runs the protocol engine and exposes the five
// configuration registers. SDA is open-drain: sda_drive_low = 1 pulls
// the pad low. Assumes an external pull-up on SDA and no other
// device that stretches SCL.
module cfg_i2c_regfile
    import cfg_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [PIN_W-1:0] addr_pins,
    output logic             sda_drive_low,
    output logic [REG_W-1:0] mask_cfg,
    output logic [REG_W-1:0] port_a_cfg,
    output logic [REG_W-1:0] port_b_cfg,
    output logic [REG_W-1:0] port_c_cfg,
    output logic [REG_W-1:0] switch_cfg
);

    logic                           scl_s, scl_p, sda_s, sda_p;
    logic                           wr_en;
    logic [REG_W-1:0]               wr_data;
    logic [REG_W-1:0]               ptr;
    logic [REG_W-1:0]               rd_data;
    logic                           start_det, stop_det;
    eng_state_t                     eng_state;
    logic [NUM_REGS-1:0][REG_W-1:0] regs;

    cfg_line_sync #(.STAGES(2)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in),
        .line_s(scl_s), .line_p(scl_p)
    );

    cfg_line_sync #(.STAGES(2)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in),
        .line_s(sda_s), .line_p(sda_p)
    );

    cfg_i2c_engine u_engine (
        .clk(clk), .rst_n(rst_n),
        .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
        .dev_pins(addr_pins), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr),
        .sda_low(sda_drive_low), .start_det(start_det),
        .stop_det(stop_det), .state_o(eng_state)
    );

    cfg_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
        .rd_addr(ptr), .rd_data(rd_data), .regs_o(regs)
    );

    assign mask_cfg   = regs[0];
    assign port_a_cfg = regs[1];
    assign port_b_cfg = regs[2];
    assign port_c_cfg = regs[3];
    assign switch_cfg = regs[4];

endmodule

// File: rtl/cfg_i2c_regfile_chk.sv
// Property checker for the two-wire configuration register file,
// bound to every instance of the top. Assumes a bus controller that
// keeps to the START/STOP and data-stability rules.
module cfg_i2c_regfile_chk
    import cfg_i2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             stop_det,
    input logic             sda_drive_low,
    input eng_state_t       eng_state,
    input logic [REG_W-1:0] mask_cfg,
    input logic [REG_W-1:0] port_a_cfg,
    input logic [REG_W-1:0] port_b_cfg,
    input logic [REG_W-1:0] port_c_cfg,
    input logic [REG_W-1:0] switch_cfg
);

    // R10: the pull-down only toggles while the bus clock is low
    p_sda_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !$past(scl_s));

    // R10: a STOP always leaves SDA released
    p_stop_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low);

    // R3: configuration outputs only change in the SCL low phase
    p_cfg_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({mask_cfg, port_a_cfg, port_b_cfg, port_c_cfg, switch_cfg})
        |-> !$past(scl_s));

    // R2: while the bus is being ignored the target stays off SDA
    p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_IGNORE) |-> !sda_drive_low);

    // R9 and R4: leaving reset shows the default register values
    p_reset_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_cfg == 8'h00 && port_a_cfg == 8'h10 &&
                          port_b_cfg == 8'h10 && port_c_cfg == 8'h10 &&
                          switch_cfg == 8'h00));

endmodule

bind cfg_i2c_regfile cfg_i2c_regfile_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_drive_low(sda_drive_low), .eng_state(eng_state),
    .mask_cfg(mask_cfg), .port_a_cfg(port_a_cfg), .port_b_cfg(port_b_cfg),
    .port_c_cfg(port_c_cfg), .switch_cfg(switch_cfg)
);

// File: tb/cfg_i2c_regfile_tb_top.sv
// Bench: a behavioural bus controller plus a register model that is
// compared with the five configuration outputs on every clock.
module cfg_i2c_regfile_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 16;       // SCL high/low time in clocks
    localparam int Q          = HALF / 2;
    localparam int WR_LAT     = 4;        // SCL fall to register update

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] pins = 3'b011;
    logic       sda_drive_low;
    logic [7:0] mask_cfg, port_a_cfg, port_b_cfg, port_c_cfg, switch_cfg;
    logic       sda_line;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] exp_regs [5];
    int         model_ptr = 0;
    int         pend_cnt  = 0;
    int         pend_idx  = 0;
    logic [7:0] pend_val  = 8'h00;

    assign sda_line = m_sda & ~sda_drive_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_i2c_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .addr_pins(pins), .sda_drive_low(sda_drive_low),
        .mask_cfg(mask_cfg), .port_a_cfg(port_a_cfg), .port_b_cfg(port_b_cfg),
        .port_c_cfg(port_c_cfg), .switch_cfg(switch_cfg)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_defaults();
        for (int i = 0; i < 5; i++) exp_regs[i] = (i >= 1 && i <= 3) ? 8'h10 : 8'h00;
        model_ptr = 0;
        pend_cnt  = 0;
    endtask

    // Apply a scheduled register update in the cycle the design takes it
    always @(posedge clk) begin
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0 && pend_idx < 5) exp_regs[pend_idx] = pend_val;
        end
    end

    // R3 R4 R7 R9: compare every configuration output on every clock
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (rst_n) begin
            n_checks++;
            if ({mask_cfg, port_a_cfg, port_b_cfg, port_c_cfg, switch_cfg} !==
                {exp_regs[0], exp_regs[1], exp_regs[2], exp_regs[3], exp_regs[4]}) begin
                n_fail++;
                $display("FAIL R3/R4 per-clock regs act=%h_%h_%h_%h_%h exp=%h_%h_%h_%h_%h",
                         mask_cfg, port_a_cfg, port_b_cfg, port_c_cfg, switch_cfg,
                         exp_regs[0], exp_regs[1], exp_regs[2], exp_regs[3], exp_regs[4]);
            end
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; ticks(HALF);
        m_scl = 1'b0; ticks(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; ticks(Q);
        m_scl = 1'b1; ticks(HALF);
        m_sda = 1'b0; ticks(HALF);
        m_scl = 1'b0; ticks(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; ticks(Q);
        m_scl = 1'b1; ticks(HALF);
        m_sda = 1'b1; ticks(HALF);
    endtask

    // Send one byte MSB first; return 1 if the target acknowledged
    task automatic send_byte(input logic [7:0] b, input bit sched, input int sidx,
                             output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; ticks(Q);
            m_scl = 1'b1; ticks(HALF);
            m_scl = 1'b0;
            if (i == 0 && sched) begin
                pend_cnt = WR_LAT; pend_idx = sidx; pend_val = b;
            end
            ticks(Q);
        end
        m_sda = 1'b1; ticks(Q);
        m_scl = 1'b1; ticks(HALF/2);
        acked = (sda_line == 1'b0);
        ticks(HALF/2);
        m_scl = 1'b0; ticks(Q);
    endtask

    // Receive one byte MSB first, then send a NACK
    task automatic recv_byte(output logic [7:0] v);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            ticks(Q);
            m_scl = 1'b1; ticks(HALF/2);
            v[i] = sda_line;
            ticks(HALF/2);
            m_scl = 1'b0;
        end
        ticks(Q);
        m_sda = 1'b1; ticks(Q);
        m_scl = 1'b1; ticks(HALF);
        m_scl = 1'b0; ticks(Q);
    endtask

    // Write transfer: address+W, pointer, one data byte
    task automatic wr_txn(input bit rs, input logic [6:0] a7, input logic [7:0] p,
                          input logic [7:0] d, input bit stop_after, input string tag);
        bit hit, ack;
        hit = (a7 == {4'b1001, pins});
        if (rs) bus_rstart(); else bus_start();
        send_byte({a7, 1'b0}, 1'b0, 0, ack);
        check({tag, " addr ack"}, ack, hit);
        send_byte(p, 1'b0, 0, ack);
        check({tag, " ptr ack"}, ack, hit);
        if (hit) model_ptr = p;
        send_byte(d, hit && (p < 5), p, ack);
        check({tag, " data ack"}, ack, hit);
        if (stop_after) bus_stop();
    endtask

    // Read transfer, optionally preceded by a pointer phase
    task automatic rd_txn(input bit set_ptr, input logic [7:0] p, input string tag);
        bit ack;
        logic [7:0] v, expv;
        logic [6:0] a7;
        a7 = {4'b1001, pins};
        bus_start();
        if (set_ptr) begin
            send_byte({a7, 1'b0}, 1'b0, 0, ack);
            check({tag, " ptr-phase addr ack"}, ack, 1'b1);
            send_byte(p, 1'b0, 0, ack);
            check({tag, " ptr-phase ptr ack"}, ack, 1'b1);
            model_ptr = p;
            bus_rstart();
        end
        send_byte({a7, 1'b1}, 1'b0, 0, ack);
        check({tag, " read addr ack"}, ack, 1'b1);
        recv_byte(v);
        expv = (model_ptr < 5) ? exp_regs[model_ptr] : 8'h00;
        check({tag, " read data"}, v, expv);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        bit ack;
        model_defaults();
        ticks(6);
        rst_n = 1'b1;
        ticks(6);

        // R4 R9: reset values
        check("R4 mask reset", mask_cfg, 8'h00);
        check("R4 port_a reset", port_a_cfg, 8'h10);
        check("R4 port_b reset", port_b_cfg, 8'h10);
        check("R4 port_c reset", port_c_cfg, 8'h10);
        check("R4 switch reset", switch_cfg, 8'h00);
        check("R10 idle release", sda_drive_low, 1'b0);

        // R1 R3: write to port A at address 0x4B
        wr_txn(1'b0, 7'h4B, 8'h01, 8'h0B, 1'b1, "R1 R3 write port A");
        check("R3 port_a after write", port_a_cfg, 8'h0B);
        check("R10 released after stop", sda_drive_low, 1'b0);

        // R8: two writes chained by a repeated START
        wr_txn(1'b0, 7'h4B, 8'h00, 8'h1F, 1'b0, "R8 chain first");
        wr_txn(1'b1, 7'h4B, 8'h04, 8'h03, 1'b1, "R8 chain second");
        check("R8 mask after chain", mask_cfg, 8'h1F);
        check("R8 switch after chain", switch_cfg, 8'h03);

        // R5: pointer set then repeated-start read
        rd_txn(1'b1, 8'h01, "R5 read port A");
        rd_txn(1'b1, 8'h00, "R5 read mask");

        // R6: pointer survives; read again without pointer phase
        rd_txn(1'b0, 8'h00, "R6 reread mask");
        wr_txn(1'b0, 7'h4B, 8'h02, 8'hA6, 1'b1, "R6 write port B");
        rd_txn(1'b0, 8'h00, "R6 read port B no ptr");

        // R2: wrong address, then a byte carrying the right address
        bus_start();
        send_byte({7'h4A, 1'b0}, 1'b0, 0, ack);
        check("R2 wrong addr nack", ack, 1'b0);
        send_byte({7'h4B, 1'b0}, 1'b0, 0, ack);
        check("R2 later match ignored", ack, 1'b0);
        send_byte(8'h03, 1'b0, 0, ack);
        check("R2 ptr ignored", ack, 1'b0);
        send_byte(8'h55, 1'b0, 0, ack);
        check("R2 data ignored", ack, 1'b0);
        bus_stop();
        check("R2 port_c untouched", port_c_cfg, 8'h10);
        rd_txn(1'b0, 8'h00, "R2 pointer kept");

        // R7: out-of-range pointer writes dropped, reads return zero
        wr_txn(1'b0, 7'h4B, 8'h05, 8'hAA, 1'b1, "R7 write ptr 5");
        rd_txn(1'b0, 8'h00, "R7 read ptr 5");
        rd_txn(1'b1, 8'hFF, "R7 read ptr FF");
        check("R7 mask unchanged", mask_cfg, 8'h1F);

        // R11: second data byte in one transfer is refused
        wr_txn(1'b0, 7'h4B, 8'h03, 8'h07, 1'b0, "R11 first data");
        send_byte(8'h09, 1'b0, 0, ack);
        check("R11 second data nack", ack, 1'b0);
        bus_stop();
        check("R11 port_c keeps first", port_c_cfg, 8'h07);

        // R1: strap pins change the address
        pins = 3'b101;
        ticks(4);
        wr_txn(1'b0, 7'h4D, 8'h04, 8'h01, 1'b1, "R1 new address");
        check("R1 switch via 0x4D", switch_cfg, 8'h01);
        wr_txn(1'b0, 7'h4B, 8'h04, 8'h02, 1'b1, "R1 old address refused");
        check("R1 switch unchanged", switch_cfg, 8'h01);

        // R9: reset restores registers and pointer
        bus_start();
        send_byte({7'h4D, 1'b0}, 1'b0, 0, ack);
        check("R9 ptr-only addr ack", ack, 1'b1);
        send_byte(8'h02, 1'b0, 0, ack);
        check("R9 ptr-only ptr ack", ack, 1'b1);
        bus_stop();
        rst_n = 1'b0;
        model_defaults();
        ticks(4);
        rst_n = 1'b1;
        ticks(4);
        check("R9 port_b default", port_b_cfg, 8'h10);
        check("R9 port_c default", port_c_cfg, 8'h10);
        check("R9 mask default", mask_cfg, 8'h00);
        rd_txn(1'b0, 8'h00, "R9 pointer back to 0");

        ticks(20);
        finish_run();
    end

endmodule